// File: doc/BRIEF.md
# Dual-Enable Asynchronous SRAM Model

This block is a synthesizable, clock-sampled functional model of a byte-wide static RAM. It has two chip enables of opposite polarity, an active-low write enable and an active-low output enable. The bidirectional data pin is split into a data-in bus, a data-out bus and an output-drive flag. A board-level wrapper can turn these three into a tri-state pin.

Each clock cycle the four control levels are sampled and decoded into one of four modes: standby, output disabled, read or write. A write is open while the device is selected and write enable is low. The byte and address held at the last sampled edge of that window are committed when the window closes, whichever of the three signals closes it. The array depth is a parameter, so simulation stays small. Address bits above the modelled depth are folded away.

Top module: `sram_dual_enable`

## Requirements
- R1: The device is selected only when `ce_lo_n`=0 and `ce_hi`=1. Whenever it is not selected, `standby`=1, `dout_en`=0 and `dout`=0 in the same cycle, whatever the other inputs are.
- R2: When selected with `we_n`=1 and `oe_n`=0, `dout_en`=1 and `dout` shows the stored byte at `addr` combinationally, in the same cycle.
- R3: When selected with `we_n`=1 and `oe_n`=1, `dout_en`=0, `dout`=0 and `standby`=0.
- R4: When selected with `we_n`=0, `dout_en`=0 and `dout`=0 for either level of `oe_n`.
- R5: A write window is open in every sampled cycle where the device is selected and `we_n`=0. A window can be closed by raising `we_n`. From the first cycle in which it is seen closed, a read of the written location returns the new byte, including a read in that very cycle.
- R6: Raising `ce_lo_n` or lowering `ce_hi` also closes the window and commits the write, in the same way as raising `we_n`.
- R7: The location is selected by the low `IDX_W` bits of `addr`. Addresses that differ only in higher bits refer to the same byte.
- R8: After synchronous reset, every location reads 0.
- R9: If `din` or `addr` changes while a window stays open, only the values sampled at the last clock edge before the window closes are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset; clears the array |
| addr | input | ADDR_W (18) | Byte address |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| din | input | DATA_W (8) | Data presented to the pin for writing |
| dout | output | DATA_W (8) | Read data; zero when not driving |
| dout_en | output | 1 | High when the pin would be driven |
| standby | output | 1 | High when the device is deselected |

## Verification
The bench closes write windows with each of the three terminating signals. A model that honoured only `we_n` would leave the byte unwritten when a chip enable ends the write. It reads the location in the very cycle the window closes. A design without the forwarding path would return the stale byte there. It changes the data across a multi-cycle window, so a design that captured at the window's start writes the wrong value. It also aliases high address bits and holds `oe_n` low during writes, where a careless decode would drive the pin against incoming data.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_HIZ     = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } sram_mode_e;

    typedef struct packed {
        logic       sel;
        logic       win;
        logic       drive;
        sram_mode_e mode;
    } sram_ctrl_s;

    function automatic sram_mode_e decode_mode(
        input logic ce_lo_n,
        input logic ce_hi,
        input logic we_n,
        input logic oe_n
    );
        sram_mode_e m;
        if (ce_lo_n || !ce_hi)
            m = MODE_STANDBY;
        else if (!we_n)
            m = MODE_WRITE;
        else if (!oe_n)
            m = MODE_READ;
        else
            m = MODE_HIZ;
        return m;
    endfunction

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_pkg::*;
(
    input  logic       ce_lo_n,
    input  logic       ce_hi,
    input  logic       we_n,
    input  logic       oe_n,
    output sram_ctrl_s ctrl
);
    sram_mode_e mode;

    always_comb begin
        mode       = decode_mode(ce_lo_n, ce_hi, we_n, oe_n);
        ctrl.mode  = mode;
        ctrl.sel   = (mode != MODE_STANDBY);
        ctrl.win   = (mode == MODE_WRITE);
        ctrl.drive = (mode == MODE_READ);
    end
endmodule

// File: rtl/sram_write_window.sv
module sram_write_window #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [DATA_W-1:0] commit_data
);
    logic              win_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
        end else begin
            win_q <= win;
            if (win) begin
                idx_q  <= idx;
                data_q <= wdata;
            end
        end
    end

    assign commit      = win_q && !win;
    assign commit_idx  = idx_q;
    assign commit_data = data_q;

    // R5: a closing window yields exactly one commit
    a_r5_single_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/sram_store.sv
module sram_store #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (commit) begin
            mem[widx] <= wdata;
        end
    end

    // forward a commit that is pending in the current cycle
    assign rdata = (commit && (widx == ridx)) ? wdata : mem[ridx];

    // R5: the committed byte lands in the array
    a_r5_commit_lands: assert property (@(posedge clk) disable iff (rst)
        commit |=> mem[$past(widx)] == $past(wdata));

    // R8: after reset the array reads zero
    a_r8_reset_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !commit) |-> rdata == '0);
endmodule

// File: rtl/sram_dual_enable.sv
module sram_dual_enable
    import sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              standby
);
    sram_ctrl_s        ctrl;
    logic [IDX_W-1:0]  idx;
    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] rdata;

    assign idx = addr[IDX_W-1:0];

    generate
        if (ADDR_W > IDX_W) begin : g_fold
            logic addr_hi_unused;
            assign addr_hi_unused = ^addr[ADDR_W-1:IDX_W];
        end
    endgenerate

    sram_mode_decode u_dec (
        .ce_lo_n (ce_lo_n),
        .ce_hi   (ce_hi),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .ctrl    (ctrl)
    );

    sram_write_window #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_win (
        .clk         (clk),
        .rst         (rst),
        .win         (ctrl.win),
        .idx         (idx),
        .wdata       (din),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    sram_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .commit(commit),
        .widx  (commit_idx),
        .wdata (commit_data),
        .ridx  (idx),
        .rdata (rdata)
    );

    assign dout_en = ctrl.drive;
    assign dout    = ctrl.drive ? rdata : '0;
    assign standby = !ctrl.sel;

    // R1: deselected means no drive
    a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        standby |-> (!dout_en && dout == '0));

    // R4: no drive while the write enable is low on a selected device
    a_r4_write_silent: assert property (@(posedge clk) disable iff (rst)
        (!ce_lo_n && ce_hi && !we_n) |-> !dout_en);

    // R3: selected with both enables high stays quiet
    a_r3_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ce_lo_n && ce_hi && we_n && oe_n) |-> (!dout_en && !standby));
endmodule

// File: tb/tb_sram_dual_enable.sv
module tb_sram_dual_enable;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 18;
    localparam int IDX_W  = 6;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic              ce_lo_n, ce_hi, we_n, oe_n;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] dout;
    logic              dout_en, standby;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DATA_W-1:0] model [DEPTH];
    logic              m_win;
    logic [IDX_W-1:0]  m_idx;
    logic [DATA_W-1:0] m_data;

    always #(CLK_P/2) clk = ~clk;

    sram_dual_enable #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi),
        .we_n(we_n), .oe_n(oe_n), .din(din), .dout(dout),
        .dout_en(dout_en), .standby(standby)
    );

    function automatic string auto_tag(logic cl, logic ch, logic we, logic oe);
        if (cl || !ch) return "R1";
        if (!we)       return "R4";
        if (!oe)       return "R2";
        return "R3";
    endfunction

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // drive one cycle of controls, update the model, check the outputs
    task automatic apply(logic cl, logic ch, logic we, logic oe,
                         logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, string tag);
        logic sel, win, drv;
        logic [DATA_W-1:0] exp_q;
        string t;
        @(negedge clk);
        ce_lo_n = cl; ce_hi = ch; we_n = we; oe_n = oe; addr = a; din = d;
        sel = !cl && ch;
        win = sel && !we;
        drv = sel && we && !oe;
        if (m_win && !win) model[m_idx] = m_data;
        if (win) begin
            m_idx  = a[IDX_W-1:0];
            m_data = d;
        end
        m_win = win;
        exp_q = drv ? model[a[IDX_W-1:0]] : '0;
        t = (tag == "") ? auto_tag(cl, ch, we, oe) : tag;
        #2;
        check(t, "dout_en", 16'(dout_en), 16'(drv));
        check(t, "standby", 16'(standby), 16'(!sel));
        check(t, "dout",    16'(dout),    16'(exp_q));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        m_win = 1'b0; m_idx = '0; m_data = '0;
        rst = 1'b1; ce_lo_n = 1'b1; ce_hi = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset contents read zero
        for (int i = 0; i < 4; i++) apply(0, 1, 1, 0, ADDR_W'(i * 9), 8'hFF, "R8");
        // R1: each way of deselecting
        apply(1, 1, 1, 0, 18'd3, 8'h00, "R1");
        apply(0, 0, 1, 0, 18'd3, 8'h00, "R1");
        apply(1, 0, 0, 0, 18'd3, 8'h00, "R1");
        // R3: output disabled
        apply(0, 1, 1, 1, 18'd3, 8'h00, "R3");

        // R4/R5: write closed by we_n, read in the closing cycle (forwarding)
        apply(0, 1, 0, 0, 18'd5, 8'hA5, "R4");
        apply(0, 1, 1, 0, 18'd5, 8'h00, "R5");
        apply(0, 1, 1, 0, 18'd5, 8'h00, "R5");
        // R6: closed by ce_lo_n
        apply(0, 1, 0, 1, 18'd9, 8'h3C, "R4");
        apply(1, 1, 0, 0, 18'd9, 8'h00, "R6");
        apply(0, 1, 1, 0, 18'd9, 8'h00, "R6");
        // R6: closed by ce_hi
        apply(0, 1, 0, 0, 18'd12, 8'h7E, "R4");
        apply(0, 0, 0, 0, 18'd12, 8'h00, "R6");
        apply(0, 1, 1, 0, 18'd12, 8'h00, "R6");
        // R9: data and address move during an open window
        apply(0, 1, 0, 0, 18'd20, 8'h11, "R9");
        apply(0, 1, 0, 0, 18'd21, 8'h22, "R9");
        apply(0, 1, 0, 0, 18'd22, 8'h33, "R9");
        apply(0, 1, 1, 0, 18'd22, 8'h00, "R9");
        apply(0, 1, 1, 0, 18'd20, 8'h00, "R9");
        apply(0, 1, 1, 0, 18'd21, 8'h00, "R9");
        // R7: high address bits alias
        apply(0, 1, 0, 1, 18'h2_C007, 8'h5A, "R7");
        apply(0, 1, 1, 1, 18'h0_0007, 8'h00, "R7");
        apply(0, 1, 1, 0, 18'h0_0007, 8'h00, "R7");
        apply(0, 1, 1, 0, 18'h1_0047, 8'h00, "R7");

        // constrained random mix
        for (int k = 0; k < 1500; k++) begin
            logic cl, ch, we, oe;
            logic [ADDR_W-1:0] a;
            cl = ($urandom % 6) == 0;
            ch = ($urandom % 6) != 0;
            we = ($urandom % 3) != 0;
            oe = ($urandom % 4) == 0;
            a  = ADDR_W'($urandom);
            a[IDX_W-1:0] = IDX_W'($urandom % 16);
            apply(cl, ch, we, oe, a, 8'($urandom), "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule